// File: doc/BRIEF.md
# Parameter RAM Safeload Transfer Controller

This block lets a host change a handful of signal-processing coefficients while the processing core keeps running. The host fills a small bank of staging slots. Each slot pairs a parameter RAM address with a data word. The host then arms a commit. At the next audio frame boundary the controller walks the slots in order and copies every filled one into the parameter RAM. The whole batch therefore lands inside one frame, and the core never sees a half-updated filter.

The core shares the RAM with this block. The controller writes only in cycles where the core reports that it is not using the RAM. When the core is busy on a filled slot, the controller holds that slot and tries it again on the next cycle. When the walk ends, the controller gives a one-cycle done pulse, empties the bank and opens staging to the host again. Staging writes and commits that arrive while a batch is armed or in flight are dropped.

Top module: `pram_safeload_ctrl`

## Requirements
- R1: After reset `ram_we` and `xfer_done` are low, `stg_ready` is high and every slot is empty.
- R2: While `stg_ready` is high, a pulse on `stg_we` fills slot `stg_sel` with `stg_addr` and `stg_data`, where slot indices run from 0 to NUM_SLOTS-1. A write with `stg_sel` at NUM_SLOTS or above fills nothing. This holds only when R3 does not apply.
- R3: When a staging write carries an address that a filled slot already holds, that slot's data is replaced and `stg_sel` is disregarded. No second slot is filled, so the address is written to the RAM once, with the newest data.
- R4: A `commit` pulse while `stg_ready` is high arms the batch. `stg_ready` goes low on the next cycle, and no RAM write occurs until `frame_start` is seen.
- R5: The walk starts on the cycle after an armed `frame_start` is sampled. The controller examines one slot per cycle, in ascending index order from slot 0. Empty slots are skipped, and each filled slot is written once.
- R6: `ram_we` is never high while `core_busy` is high. A filled slot met while the core is busy is held and written on the first cycle with `core_busy` low.
- R7: With no busy stalls, `xfer_done` is high for exactly one cycle, NUM_SLOTS+1 cycles after the `frame_start` sample. In that same cycle `stg_ready` is high and every slot is empty, so a later batch that has no new staging writes produces no RAM writes.
- R8: Staging writes and commits made while `stg_ready` is low have no effect. They are not written by the batch in flight, and a later frame start does not launch a new batch.
- R9: A batch committed with every slot empty still runs its walk and gives its done pulse, but produces no RAM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stg_we | input | 1 | Staging write strobe |
| stg_sel | input | SEL_W (3) | Staging slot index |
| stg_addr | input | ADDR_W (8) | Parameter RAM address to stage |
| stg_data | input | DATA_W (22) | Parameter word to stage |
| stg_ready | output | 1 | High when staging writes and commits are accepted |
| commit | input | 1 | Arms the staged batch |
| frame_start | input | 1 | Audio frame boundary pulse |
| core_busy | input | 1 | Core is using the parameter RAM this cycle |
| ram_we | output | 1 | Parameter RAM write enable |
| ram_addr | output | ADDR_W (8) | Parameter RAM write address |
| ram_data | output | DATA_W (22) | Parameter RAM write data |
| xfer_done | output | 1 | One-cycle pulse when a batch ends |

## Verification
A corrupted slot flag has two possible effects. It can drop a write from the batch, or it can replay a stale entry in the next batch. The RAM write log shows either one within NUM_SLOTS cycles of the frame start that follows. A wrong walk pointer or a wrong state shows up as writes in the wrong order, as a write issued while the core is busy, or as a done pulse that comes early, comes late or never comes. The bench therefore checks the address, data and order of the writes in every batch. It also checks the distance from the frame edge to the done pulse, the silence on the RAM port while the core is busy, and the batch that runs after each transfer.

// File: rtl/pram_safeload_ctrl.sv
module pram_safeload_ctrl #(
  parameter int NUM_SLOTS = 5,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 22,
  parameter int SEL_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stg_we,
  input  logic [SEL_W-1:0]  stg_sel,
  input  logic [ADDR_W-1:0] stg_addr,
  input  logic [DATA_W-1:0] stg_data,
  output logic              stg_ready,
  input  logic              commit,
  input  logic              frame_start,
  input  logic              core_busy,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_data,
  output logic              xfer_done
);

  localparam logic [SEL_W-1:0] LAST_IDX  = SEL_W'(NUM_SLOTS - 1);
  localparam logic [SEL_W:0]   SLOT_LIM  = (SEL_W + 1)'(NUM_SLOTS);

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_MOVE} state_t;

  state_t              state;
  logic [SEL_W-1:0]    idx;
  logic [NUM_SLOTS-1:0] valid;
  logic [ADDR_W-1:0]   slot_addr [NUM_SLOTS];
  logic [DATA_W-1:0]   slot_data [NUM_SLOTS];

  logic              hit;
  logic [SEL_W-1:0]  hit_idx;
  logic [SEL_W-1:0]  wr_idx;
  logic              wr_ok;
  logic              cur_valid;
  logic              step;

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (valid[i] && slot_addr[i] == stg_addr) begin
        hit     = 1'b1;
        hit_idx = SEL_W'(i);
      end
    end
  end

  assign stg_ready = (state == S_IDLE);
  assign wr_idx    = hit ? hit_idx : stg_sel;
  assign wr_ok     = stg_we && stg_ready && (hit || ({1'b0, stg_sel} < SLOT_LIM));
  assign cur_valid = ({1'b0, idx} < SLOT_LIM) && valid[idx];
  assign step      = (state == S_MOVE) && (!cur_valid || !core_busy);

  assign ram_we   = (state == S_MOVE) && cur_valid && !core_busy;
  assign ram_addr = slot_addr[idx];
  assign ram_data = slot_data[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      idx       <= '0;
      valid     <= '0;
      xfer_done <= 1'b0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        slot_addr[i] <= '0;
        slot_data[i] <= '0;
      end
    end else begin
      xfer_done <= 1'b0;
      if (wr_ok) begin
        valid[wr_idx]     <= 1'b1;
        slot_addr[wr_idx] <= stg_addr;
        slot_data[wr_idx] <= stg_data;
      end
      case (state)
        S_IDLE:  if (commit) state <= S_ARMED;
        S_ARMED: if (frame_start) begin
                   state <= S_MOVE;
                   idx   <= '0;
                 end
        S_MOVE:  if (step) begin
                   if (idx == LAST_IDX) begin
                     state     <= S_IDLE;
                     valid     <= '0;
                     xfer_done <= 1'b1;
                     idx       <= '0;
                   end else begin
                     idx <= idx + SEL_W'(1);
                   end
                 end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r6_no_write_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !core_busy);

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  a_r7_ready_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> stg_ready);

  a_r5_write_advances: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> (state == S_IDLE) || (idx == $past(idx) + SEL_W'(1)));

endmodule

// File: tb/pram_safeload_ctrl_bench.sv
`timescale 1ns/1ps
module pram_safeload_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stg_we = 1'b0;
  logic [2:0]  stg_sel = '0;
  logic [7:0]  stg_addr = '0;
  logic [21:0] stg_data = '0;
  logic        stg_ready;
  logic        commit = 1'b0;
  logic        frame_start = 1'b0;
  logic        core_busy = 1'b0;
  logic        ram_we;
  logic [7:0]  ram_addr;
  logic [21:0] ram_data;
  logic        xfer_done;

  int checks = 0, fails = 0;
  int cyc = 0, nlog = 0, ndone = 0, frame_cyc = 0, done_cyc = 0, busy_wr = 0;
  logic [7:0]  log_a [16];
  logic [21:0] log_d [16];

  always #2.5 clk = ~clk;

  pram_safeload_ctrl u_pram_safeload_ctrl (
    .clk(clk), .rst_n(rst_n), .stg_we(stg_we), .stg_sel(stg_sel),
    .stg_addr(stg_addr), .stg_data(stg_data), .stg_ready(stg_ready),
    .commit(commit), .frame_start(frame_start), .core_busy(core_busy),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_data(ram_data),
    .xfer_done(xfer_done));

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (ram_we) begin
        if (nlog < 16) begin log_a[nlog] = ram_addr; log_d[nlog] = ram_data; end
        nlog++;
        if (core_busy) busy_wr++;
      end
      if (xfer_done) begin ndone++; done_cyc = cyc; end
      if (frame_start) frame_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stage(input logic [2:0] s, input logic [7:0] a, input logic [21:0] d);
    @(negedge clk);
    stg_we = 1'b1; stg_sel = s; stg_addr = a; stg_data = d;
    @(negedge clk);
    stg_we = 1'b0;
  endtask

  task automatic pulse_commit();
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic clear_log();
    nlog = 0; ndone = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(stg_ready === 1'b1, "R1 stg_ready", stg_ready, 1);
    chk(ram_we === 1'b0, "R1 ram_we", ram_we, 0);
    chk(xfer_done === 1'b0, "R1 xfer_done", xfer_done, 0);
    clear_log();
    pulse_commit(); pulse_frame(); idle(10);
    chk(nlog == 0, "R1 slots empty after reset", nlog, 0);
  endtask

  task automatic t_basic();
    clear_log();
    stage(3'd4, 8'h40, 22'h2AAAAA);
    stage(3'd0, 8'h10, 22'h012345);
    stage(3'd2, 8'h20, 22'h3FFFFF);
    pulse_commit();
    chk(stg_ready === 1'b0, "R4 ready low when armed", stg_ready, 0);
    idle(6);
    chk(nlog == 0, "R4 no write before frame", nlog, 0);
    pulse_frame(); idle(10);
    chk(nlog == 3, "R5 write count", nlog, 3);
    chk(log_a[0] == 8'h10 && log_d[0] == 22'h012345, "R5 first write slot0", log_a[0], 8'h10);
    chk(log_a[1] == 8'h20 && log_d[1] == 22'h3FFFFF, "R5 second write slot2", log_a[1], 8'h20);
    chk(log_a[2] == 8'h40 && log_d[2] == 22'h2AAAAA, "R5 third write slot4", log_a[2], 8'h40);
    chk(ndone == 1, "R7 one done pulse", ndone, 1);
    chk(done_cyc - frame_cyc == 6, "R7 done latency", done_cyc - frame_cyc, 6);
    chk(stg_ready === 1'b1, "R7 ready after done", stg_ready, 1);
    clear_log();
    pulse_commit(); pulse_frame(); idle(10);
    chk(nlog == 0, "R7 slots cleared after batch", nlog, 0);
  endtask

  task automatic t_dedup();
    clear_log();
    stage(3'd1, 8'h55, 22'h000111);
    stage(3'd3, 8'h66, 22'h000222);
    stage(3'd4, 8'h55, 22'h000333);
    stage(3'd7, 8'h77, 22'h000444);
    stage(3'd5, 8'h78, 22'h000555);
    pulse_commit(); pulse_frame(); idle(10);
    chk(nlog == 2, "R3 R2 write count", nlog, 2);
    chk(log_a[0] == 8'h55 && log_d[0] == 22'h000333, "R3 newest data kept", log_d[0], 22'h000333);
    chk(log_a[1] == 8'h66 && log_d[1] == 22'h000222, "R3 other slot intact", log_d[1], 22'h000222);
  endtask

  task automatic t_busy();
    clear_log(); busy_wr = 0;
    stage(3'd0, 8'h01, 22'h0000AA);
    stage(3'd1, 8'h02, 22'h0000BB);
    @(negedge clk); core_busy = 1'b1;
    pulse_commit(); pulse_frame(); idle(5);
    chk(nlog == 0, "R6 no write while busy", nlog, 0);
    chk(ndone == 0, "R6 no done while stalled", ndone, 0);
    core_busy = 1'b0;
    idle(10);
    chk(nlog == 2 && busy_wr == 0, "R6 writes after busy drops", nlog, 2);
    chk(log_a[0] == 8'h01 && log_a[1] == 8'h02, "R6 stalled order kept", log_a[1], 8'h02);
    chk(ndone == 1, "R6 done after stall", ndone, 1);
  endtask

  task automatic t_ignored();
    clear_log();
    stage(3'd0, 8'h90, 22'h00ABCD);
    pulse_commit();
    stage(3'd2, 8'h91, 22'h00DCBA);
    pulse_commit();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    stg_we = 1'b1; stg_sel = 3'd3; stg_addr = 8'h92; stg_data = 22'h1;
    commit = 1'b1;
    @(negedge clk); stg_we = 1'b0; commit = 1'b0;
    idle(10);
    chk(nlog == 1 && log_a[0] == 8'h90, "R8 only pre-commit entry", nlog, 1);
    clear_log();
    pulse_frame(); idle(10);
    chk(ndone == 0, "R8 commit during walk ignored", ndone, 0);
    pulse_commit(); pulse_frame(); idle(10);
    chk(nlog == 0, "R8 write during walk ignored", nlog, 0);
  endtask

  task automatic t_empty();
    clear_log();
    pulse_commit(); pulse_frame(); idle(10);
    chk(ndone == 1, "R9 done on empty batch", ndone, 1);
    chk(nlog == 0, "R9 no writes on empty batch", nlog, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_basic();
    t_dedup();
    t_busy();
    t_ignored();
    t_empty();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule